// File: doc/BRIEF.md
# Dual-Mode Program Counter Unit

This unit holds the architectural program counter of a core that runs in one of two instruction-set states. In the wide state every instruction is 32 bits long. In the narrow state every instruction is 16 bits long. The unit updates the counter only on a cycle where the step enable is high. On such a cycle it adds the size of the current instruction to the counter, or it loads a branch target when a branch is taken. The target is forced onto an instruction boundary of the active state before it is loaded.

The unit has a second output that gives the value software gets when it names the program counter as an operand. Because of the two-deep prefetch that the programming model assumes, this value is the current instruction address plus two instruction sizes. The offset is therefore 8 in the wide state and 4 in the narrow state. For example, a wide instruction at 0x8054 that reads the counter gets 0x805C. Instruction decode and the mechanism that switches states belong to other blocks.

Top module: `dual_pc_unit`

## Requirements
- R1: A rising clock edge with `rst_n` low loads `fetch_addr` with the parameter `RESET_VEC` (default 0x00000000), whatever the other inputs are.
- R2: With `isa_sel` = 0 (wide state), `step_en` = 1 and `br_taken` = 0, `fetch_addr` increases by 4 at the clock edge.
- R3: With `isa_sel` = 1 (narrow state), `step_en` = 1 and `br_taken` = 0, `fetch_addr` increases by 2 at the clock edge.
- R4: With `step_en` = 1, `br_taken` = 1 and `isa_sel` = 0, `fetch_addr` takes `br_target` with bits [1:0] cleared at the clock edge.
- R5: With `step_en` = 1, `br_taken` = 1 and `isa_sel` = 1, `fetch_addr` takes `br_target` with bit 0 cleared at the clock edge.
- R6: When a taken branch and a step occur in the same cycle, the branch wins and no increment is added.
- R7: With `step_en` = 0, `fetch_addr` keeps its value at the clock edge, and `br_taken`, `br_target` and `isa_sel` have no effect on it.
- R8: With `isa_sel` = 0, `operand_pc` equals `fetch_addr` + 8 in the same cycle (0x8054 gives 0x805C).
- R9: With `isa_sel` = 1, `operand_pc` equals `fetch_addr` + 4 in the same cycle.
- R10: All additions wrap modulo 2^`ADDR_W`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| step_en | input | 1 | Instruction step; the counter updates only when this is high |
| isa_sel | input | 1 | Instruction-set state: 0 = 32-bit instructions, 1 = 16-bit instructions |
| br_taken | input | 1 | A branch is taken on this step |
| br_target | input | ADDR_W | Branch destination address |
| fetch_addr | output | ADDR_W | Address of the current instruction |
| operand_pc | output | ADDR_W | Value returned when software reads the counter |

## Verification
The counter has one register stage. The effect of reset, a step, a branch or a hold therefore shows on `fetch_addr` exactly one clock edge after the inputs are applied. `operand_pc` is combinational, so it follows `fetch_addr` and `isa_sel` in the same cycle. The bench drives inputs on the falling edge and checks `operand_pc` against its model just before the next rising edge. One time unit after that edge, once its own model has stepped, it checks `fetch_addr`. Both results are compared on every clock against a behavioural model that knows only the requirements.

// File: rtl/pc_pkg.sv
// Package: shared types and constants for the dual-mode program counter.
// Assumes: instruction sizes are fixed per state (4 bytes wide, 2 bytes narrow).
package pc_pkg;
    typedef enum logic {
        ISA_WIDE   = 1'b0,
        ISA_NARROW = 1'b1
    } isa_e;

    localparam int WIDE_BYTES   = 4;
    localparam int NARROW_BYTES = 2;
    // Number of instructions the operand view runs ahead of the current one.
    localparam int PREFETCH_DEPTH = 2;
endpackage

// File: rtl/pc_target_align.sv
// Module: forces a branch target onto an instruction boundary of the active state.
// Assumes: bit 0 is always cleared; bit 1 is cleared only in the wide state.
module pc_target_align #(
    parameter int ADDR_W = 32
) (
    input  pc_pkg::isa_e        isa,
    input  logic [ADDR_W-1:0]   target,
    output logic [ADDR_W-1:0]   aligned
);
    logic keep_bit1;

    // Bit 1 survives only for 16-bit instructions.
    always_comb keep_bit1 = (isa == pc_pkg::ISA_NARROW);

    for (genvar b = 0; b < ADDR_W; b++) begin : g_bit
        if (b == 0) begin : g_clr
            assign aligned[b] = 1'b0;
        end else if (b == 1) begin : g_cond
            assign aligned[b] = target[b] & keep_bit1;
        end else begin : g_pass
            assign aligned[b] = target[b];
        end
    end
endmodule

// File: rtl/pc_next_sel.sv
// Module: chooses the next counter value: hold, sequential increment or branch.
// Assumes: a branch counts only on a stepping cycle and wins over the increment.
module pc_next_sel #(
    parameter int ADDR_W = 32
) (
    input  pc_pkg::isa_e        isa,
    input  logic                step_en,
    input  logic                br_taken,
    input  logic [ADDR_W-1:0]   cur_pc,
    input  logic [ADDR_W-1:0]   br_aligned,
    output logic [ADDR_W-1:0]   nxt_pc
);
    localparam logic [ADDR_W-1:0] INC_WIDE   = ADDR_W'(pc_pkg::WIDE_BYTES);
    localparam logic [ADDR_W-1:0] INC_NARROW = ADDR_W'(pc_pkg::NARROW_BYTES);

    logic [ADDR_W-1:0] seq_pc;

    // Sequential successor for the size of the current instruction.
    always_comb seq_pc = cur_pc + ((isa == pc_pkg::ISA_NARROW) ? INC_NARROW : INC_WIDE);

    // Priority select: no step holds, a branch beats the increment.
    always_comb begin
        if (!step_en)
            nxt_pc = cur_pc;
        else if (br_taken)
            nxt_pc = br_aligned;
        else
            nxt_pc = seq_pc;
    end
endmodule

// File: rtl/pc_state_reg.sv
// Module: the architectural counter register with synchronous active-low reset.
// Assumes: RESET_VEC is itself suitably aligned by the integrator.
module pc_state_reg #(
    parameter int                ADDR_W    = 32,
    parameter logic [ADDR_W-1:0] RESET_VEC = '0
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic [ADDR_W-1:0]   nxt_pc,
    output logic [ADDR_W-1:0]   cur_pc
);
    // Capture the selected next value, or the vector on reset.
    always_ff @(posedge clk) begin
        if (!rst_n)
            cur_pc <= RESET_VEC;
        else
            cur_pc <= nxt_pc;
    end
endmodule

// File: rtl/pc_operand_view.sv
// Module: produces the counter value software observes as an operand.
// Assumes: that value runs PREFETCH_DEPTH instructions ahead of the current one.
module pc_operand_view #(
    parameter int ADDR_W = 32
) (
    input  pc_pkg::isa_e        isa,
    input  logic [ADDR_W-1:0]   cur_pc,
    output logic [ADDR_W-1:0]   view_pc
);
    localparam logic [ADDR_W-1:0] OFS_WIDE   = ADDR_W'(pc_pkg::WIDE_BYTES * pc_pkg::PREFETCH_DEPTH);
    localparam logic [ADDR_W-1:0] OFS_NARROW = ADDR_W'(pc_pkg::NARROW_BYTES * pc_pkg::PREFETCH_DEPTH);

    // Add the state-dependent prefetch offset.
    always_comb view_pc = cur_pc + ((isa == pc_pkg::ISA_NARROW) ? OFS_NARROW : OFS_WIDE);
endmodule

// File: rtl/dual_pc_unit.sv
// Module: top of the dual-mode program counter; ties alignment, select, register
// and operand view together.
// Assumes: isa_sel is stable for the whole cycle and names the current instruction's state.
module dual_pc_unit #(
    parameter int                ADDR_W    = 32,
    parameter logic [ADDR_W-1:0] RESET_VEC = '0
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              step_en,
    input  logic              isa_sel,
    input  logic              br_taken,
    input  logic [ADDR_W-1:0] br_target,
    output logic [ADDR_W-1:0] fetch_addr,
    output logic [ADDR_W-1:0] operand_pc
);
    pc_pkg::isa_e       isa;
    logic [ADDR_W-1:0]  tgt_aligned;
    logic [ADDR_W-1:0]  nxt_pc;
    logic [ADDR_W-1:0]  cur_pc;

    // Map the raw state pin onto the shared type.
    always_comb isa = pc_pkg::isa_e'(isa_sel);

    pc_target_align #(.ADDR_W(ADDR_W)) align_i (
        .isa     (isa),
        .target  (br_target),
        .aligned (tgt_aligned)
    );

    pc_next_sel #(.ADDR_W(ADDR_W)) sel_i (
        .isa        (isa),
        .step_en    (step_en),
        .br_taken   (br_taken),
        .cur_pc     (cur_pc),
        .br_aligned (tgt_aligned),
        .nxt_pc     (nxt_pc)
    );

    pc_state_reg #(.ADDR_W(ADDR_W), .RESET_VEC(RESET_VEC)) reg_i (
        .clk    (clk),
        .rst_n  (rst_n),
        .nxt_pc (nxt_pc),
        .cur_pc (cur_pc)
    );

    pc_operand_view #(.ADDR_W(ADDR_W)) view_i (
        .isa     (isa),
        .cur_pc  (cur_pc),
        .view_pc (operand_pc)
    );

    // Drive the fetch port from the architectural register.
    always_comb fetch_addr = cur_pc;
endmodule

// File: rtl/dual_pc_unit_checker.sv
// Module: port-level temporal checks for dual_pc_unit, attached by bind.
// Assumes: only the top's ports are visible; reset is synchronous and active low.
module dual_pc_unit_checker #(
    parameter int                ADDR_W    = 32,
    parameter logic [ADDR_W-1:0] RESET_VEC = '0
) (
    input logic              clk,
    input logic              rst_n,
    input logic              step_en,
    input logic              isa_sel,
    input logic              br_taken,
    input logic [ADDR_W-1:0] br_target,
    input logic [ADDR_W-1:0] fetch_addr,
    input logic [ADDR_W-1:0] operand_pc
);
    p_reset_vec_r1: assert property (@(posedge clk)
        !rst_n |=> fetch_addr == RESET_VEC);

    p_wide_step_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (step_en && !br_taken && !isa_sel) |=> fetch_addr == $past(fetch_addr) + ADDR_W'(4));

    p_narrow_step_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (step_en && !br_taken && isa_sel) |=> fetch_addr == $past(fetch_addr) + ADDR_W'(2));

    p_wide_branch_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (step_en && br_taken && !isa_sel) |=> fetch_addr == ($past(br_target) & ~ADDR_W'(3)));

    p_narrow_branch_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (step_en && br_taken && isa_sel) |=> fetch_addr == ($past(br_target) & ~ADDR_W'(1)));

    p_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
        !step_en |=> $stable(fetch_addr));

    p_wide_view_r8: assert property (@(posedge clk) disable iff (!rst_n)
        !isa_sel |-> operand_pc == fetch_addr + ADDR_W'(8));

    p_narrow_view_r9: assert property (@(posedge clk) disable iff (!rst_n)
        isa_sel |-> operand_pc == fetch_addr + ADDR_W'(4));
endmodule

bind dual_pc_unit dual_pc_unit_checker #(.ADDR_W(ADDR_W), .RESET_VEC(RESET_VEC)) chk_i (
    .clk        (clk),
    .rst_n      (rst_n),
    .step_en    (step_en),
    .isa_sel    (isa_sel),
    .br_taken   (br_taken),
    .br_target  (br_target),
    .fetch_addr (fetch_addr),
    .operand_pc (operand_pc)
);

// File: tb/dual_pc_unit_tb_top.sv
`timescale 1ns/1ps
module dual_pc_unit_tb_top;
    localparam int          AW  = 32;
    localparam logic [31:0] VEC = 32'h0000_8000;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          step_en = 1'b0;
    logic          isa_sel = 1'b0;
    logic          br_taken = 1'b0;
    logic [AW-1:0] br_target = '0;
    logic [AW-1:0] fetch_addr;
    logic [AW-1:0] operand_pc;

    int total = 0;
    int bad = 0;
    logic [31:0] model_pc = 32'hDEAD_BEEF;

    always #2.5 clk = ~clk;

    dual_pc_unit #(.ADDR_W(AW), .RESET_VEC(VEC)) dut_i (
        .clk(clk), .rst_n(rst_n), .step_en(step_en), .isa_sel(isa_sel),
        .br_taken(br_taken), .br_target(br_target),
        .fetch_addr(fetch_addr), .operand_pc(operand_pc)
    );

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s: actual=%h expected=%h", tag, act, exp);
        end
    endtask

    // Apply one cycle of stimulus, step the model, compare both outputs.
    task automatic cycle(input logic rst, input logic en, input logic mode,
                         input logic br, input logic [31:0] tgt, input string tag);
        @(negedge clk);
        rst_n = rst; step_en = en; isa_sel = mode; br_taken = br; br_target = tgt;
        #2;
        if (rst_n === 1'b1 && model_pc !== 32'hDEAD_BEEF)
            check(mode ? "R9 narrow operand" : "R8 wide operand",
                  operand_pc, model_pc + (mode ? 32'd4 : 32'd8));
        @(posedge clk);
        if (!rst)          model_pc = VEC;
        else if (!en)      model_pc = model_pc;
        else if (br)       model_pc = tgt & (mode ? 32'hFFFF_FFFE : 32'hFFFF_FFFC);
        else               model_pc = model_pc + (mode ? 32'd2 : 32'd4);
        #1;
        check(tag, fetch_addr, model_pc);
    endtask

    initial begin
        #(5.0 * 200000);
        total++; bad++;
        $display("FAIL watchdog: actual=timeout expected=finish");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        // R1: reset with noisy inputs
        cycle(0, 1, 1, 1, 32'h1234_5677, "R1 reset vector");
        cycle(0, 1, 0, 0, 32'h0,         "R1 reset held");
        // R2: wide steps up to 0x8054, then check R8 example value
        for (int i = 0; i < 21; i++) cycle(1, 1, 0, 0, 32'h0, "R2 wide step");
        check("R8 example 0x8054", fetch_addr, 32'h0000_8054);
        #0;
        @(negedge clk); isa_sel = 0; step_en = 0; #1;
        check("R8 example operand", operand_pc, 32'h0000_805C);
        // R3: narrow steps
        for (int i = 0; i < 5; i++) cycle(1, 1, 1, 0, 32'h0, "R3 narrow step");
        // R7: hold, branch and mode ignored while not stepping
        cycle(1, 0, 0, 1, 32'hAAAA_0000, "R7 hold with branch");
        cycle(1, 0, 1, 1, 32'h5555_0002, "R7 hold narrow");
        // R4/R6: wide branch with unaligned target, branch beats step
        cycle(1, 1, 0, 1, 32'h0000_2237, "R4 R6 wide branch");
        cycle(1, 1, 0, 0, 32'h0,         "R2 after branch");
        // R5: narrow branch
        cycle(1, 1, 1, 1, 32'h0000_1235, "R5 narrow branch");
        cycle(1, 1, 1, 1, 32'h0000_4002, "R5 narrow keeps bit1");
        cycle(1, 1, 1, 0, 32'h0,         "R3 after branch");
        // R10: wraparound
        cycle(1, 1, 0, 1, 32'hFFFF_FFFC, "R4 branch to top");
        cycle(1, 1, 0, 0, 32'h0,         "R10 wide wrap");
        cycle(1, 1, 1, 1, 32'hFFFF_FFFF, "R5 branch to top narrow");
        cycle(1, 0, 1, 0, 32'h0,         "R10 narrow operand wrap");
        cycle(1, 1, 1, 0, 32'h0,         "R10 narrow wrap");
        // mixed pattern
        for (int i = 0; i < 12; i++)
            cycle(1, (i % 3) != 2, i[0], (i % 5) == 4, 32'h0010_0000 + 32'(i * 7), "R6 mixed");
        cycle(0, 1, 0, 0, 32'h0, "R1 late reset");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule